// File: doc/BRIEF.md
# Half-flash ADC interface controller

This block is a host-side sequencer for a parallel-output converter that digitises in two steps, a coarse pass and then a fine pass. A request on `start_i` carries a channel number and a handshake mode. The controller then drives chip select, the sample/hold strobe, the read strobe and the two channel-select lines. It waits for the converter's active-low conversion-done flag and captures the 10-bit result. The result leaves on `data_o` together with the channel tag and a single-cycle `valid_o` pulse.

Two handshakes are supported. In the split mode the sample strobe is held low for a minimum time and then released, which starts the fine pass. The read strobe is asserted only after the done flag falls. In the joined mode one combined strobe both starts the conversion and reads it. The bus still carries the previous result until done falls, so the capture waits a settling delay after that. The done input is asynchronous and passes through a synchroniser. A countdown limits every wait for the converter. If the converter fails to answer, the strobes are released and an error pulse is raised.

Top module: `hfadc_seq`

## Requirements
- R1: After reset `ready_o` is 1, `cs_n_o`, `sh_n_o` and `rd_n_o` are 1, and `valid_o` and `err_o` are 0.
- R2: A request is taken only while `ready_o` is 1. A `start_i` pulse during a transaction changes neither the channel lines nor the tag or number of results delivered.
- R3: `sel_o` carries the requested channel with encoding 00 = input 0, 01 = input 1, 10 = input 2, 11 = input 3. It is stable from one cycle before the sample strobe falls. With `N_CH` = 2, `sel_o[1]` is held at 0.
- R4: `cs_n_o` is 0 in every cycle in which `sh_n_o` or `rd_n_o` is 0.
- R5: In split mode (`mode_i` = 0), `sh_n_o` stays low for exactly ceil(`SAMPLE_NS`/`CLK_NS`) cycles while `rd_n_o` is high. `rd_n_o` then falls 3 cycles after `done_n_i` falls, and it stays low for `RD_CYC` cycles.
- R6: In joined mode (`mode_i` = 1), `sh_n_o` and `rd_n_o` fall in the same cycle and stay low until the result is captured.
- R7: In joined mode, data is captured 3 + ceil(`SETTLE_NS`/`CLK_NS`) cycles after `done_n_i` falls. Bus values shown before done falls are ignored.
- R8: `data_o`, `chan_o` and `valid_o` change in the same cycle, and `valid_o` is high for exactly one cycle per conversion.
- R9: After a read, `ready_o` returns to 1 exactly 3 cycles after `done_n_i` returns high, and not earlier.
- R10: If `done_n_i` does not fall within `TMO_CYC` cycles of the wait starting, all strobes are released, `err_o` pulses for one cycle together with `ready_o` rising, and no `valid_o` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request |
| chan_i | input | 2 | Requested channel |
| mode_i | input | 1 | 0 = split strobes, 1 = joined strobe |
| ready_o | output | 1 | Controller idle, request accepted |
| cs_n_o | output | 1 | Chip select, active low |
| sh_n_o | output | 1 | Sample/hold strobe, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| sel_o | output | 2 | Channel-select lines to the converter |
| done_n_i | input | 1 | Conversion-done flag, active low, asynchronous |
| data_i | input | DATA_W | Converter data bus |
| data_o | output | DATA_W | Captured result |
| chan_o | output | 2 | Channel tag of the result |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | One-cycle timeout strobe |

## Verification
Every result of this block is due a fixed number of cycles after a converter event. The read strobe falls 3 cycles after done falls: two synchroniser stages plus the state change. The joined-mode capture lands 3 + settle cycles after done falls, and the split-mode capture 3 + `RD_CYC` cycles after it. Ready returns 3 cycles after done rises, and the timeout fires `TMO_CYC` cycles after the wait begins. The bench's converter model timestamps each done edge on the falling clock edge. Each check then compares the cycle in which the output was first seen against these exact offsets, so an early or a late response both count as failures.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_SAMPLE,
      ST_CONV,
      ST_READ,
      ST_SETTLE,
      ST_RECOVER
   } seq_state_t;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hfadc_sync.sv
module hfadc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hfadc_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hfadc_timer.sv
module hfadc_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   // R5 / R10: the countdown steps by exactly one while it runs
   a_r10_timer_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1))
      else $error("timer did not step");
endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
   import hfadc_pkg::*;
#(
   parameter int CLK_NS      = 5,
   parameter int SAMPLE_NS   = 250,
   parameter int SETTLE_NS   = 20,
   parameter int RD_CYC      = 4,
   parameter int TMO_CYC     = 1000,
   parameter int DATA_W      = 10,
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        chan_i,
   input  logic              mode_i,
   output logic              ready_o,
   output logic              cs_n_o,
   output logic              sh_n_o,
   output logic              rd_n_o,
   output logic [1:0]        sel_o,
   input  logic              done_n_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] data_o,
   output logic [1:0]        chan_o,
   output logic              valid_o,
   output logic              err_o
);
   localparam int SAMPLE_CYC = max2(ceil_div(SAMPLE_NS, CLK_NS), 1);
   localparam int SETTLE_CYC = max2(ceil_div(SETTLE_NS, CLK_NS), 1);
   localparam int MAX_CYC    = max2(max2(SAMPLE_CYC, SETTLE_CYC), max2(RD_CYC, TMO_CYC));
   localparam int TW         = $clog2(MAX_CYC + 1);
   localparam logic [1:0] CH_MASK = (N_CH == 2) ? 2'b01 : 2'b11;

   if (N_CH != 2 && N_CH != 4) begin : g_bad_nch
      $error("hfadc_seq: N_CH must be 2 or 4");
   end
   if (CLK_NS < 1 || RD_CYC < 1 || TMO_CYC < 1) begin : g_bad_time
      $error("hfadc_seq: timing parameters must be positive");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("hfadc_seq: DATA_W must be positive");
   end

   seq_state_t        st, nxt;
   logic              done_s;
   logic              tmr_ld, tmr_exp;
   logic [TW-1:0]     tmr_val;
   logic              cap, err_req;
   logic [1:0]        chan_q, tag_q;
   logic              mode_q;
   logic [DATA_W-1:0] data_q;
   logic              valid_q, err_q;

   hfadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(done_n_i), .q(done_s)
   );

   hfadc_timer #(.W(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp)
   );

   always_comb begin
      nxt     = st;
      tmr_ld  = 1'b0;
      tmr_val = '0;
      cap     = 1'b0;
      err_req = 1'b0;
      unique case (st)
         ST_IDLE: if (start_i) nxt = ST_SETUP;
         ST_SETUP: begin
            nxt     = ST_SAMPLE;
            tmr_ld  = 1'b1;
            tmr_val = mode_q ? TW'(TMO_CYC - 1) : TW'(SAMPLE_CYC - 1);
         end
         ST_SAMPLE: begin
            if (!mode_q) begin
               if (tmr_exp) begin
                  nxt     = ST_CONV;
                  tmr_ld  = 1'b1;
                  tmr_val = TW'(TMO_CYC - 1);
               end
            end else if (!done_s) begin
               nxt     = ST_SETTLE;
               tmr_ld  = 1'b1;
               tmr_val = TW'(SETTLE_CYC - 1);
            end else if (tmr_exp) begin
               nxt     = ST_IDLE;
               err_req = 1'b1;
            end
         end
         ST_CONV: begin
            if (!done_s) begin
               nxt     = ST_READ;
               tmr_ld  = 1'b1;
               tmr_val = TW'(RD_CYC - 1);
            end else if (tmr_exp) begin
               nxt     = ST_IDLE;
               err_req = 1'b1;
            end
         end
         ST_READ, ST_SETTLE: begin
            if (tmr_exp) begin
               nxt     = ST_RECOVER;
               cap     = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = TW'(TMO_CYC - 1);
            end
         end
         ST_RECOVER: begin
            if (done_s) begin
               nxt = ST_IDLE;
            end else if (tmr_exp) begin
               nxt     = ST_IDLE;
               err_req = 1'b1;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         chan_q  <= '0;
         mode_q  <= 1'b0;
         tag_q   <= '0;
         data_q  <= '0;
         valid_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         st      <= nxt;
         valid_q <= cap;
         err_q   <= err_req;
         if (st == ST_IDLE && start_i) begin
            chan_q <= chan_i & CH_MASK;
            mode_q <= mode_i;
         end
         if (cap) begin
            data_q <= data_i;
            tag_q  <= chan_q;
         end
      end
   end

   assign ready_o = (st == ST_IDLE);
   assign cs_n_o  = (st == ST_IDLE);
   assign sh_n_o  = !(st == ST_SAMPLE || st == ST_SETTLE);
   assign rd_n_o  = !(st == ST_READ || st == ST_SETTLE || (st == ST_SAMPLE && mode_q));
   assign sel_o   = chan_q;
   assign data_o  = data_q;
   assign chan_o  = tag_q;
   assign valid_o = valid_q;
   assign err_o   = err_q;

   // width monitor for the split-mode sample strobe
   logic [TW-1:0] sh_lo_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || sh_n_o)        sh_lo_cnt <= '0;
      else if (sh_lo_cnt != '1)    sh_lo_cnt <= sh_lo_cnt + 1'b1;
   end

   a_r5_sh_min_width: assert property (@(posedge clk) disable iff (!rst_n)
      (sh_n_o && !$past(sh_n_o) && rd_n_o) |-> (sh_lo_cnt >= TW'(SAMPLE_CYC)))
      else $error("sample strobe too short");

   a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_n_o && $past(sh_n_o)) |-> $stable(sel_o))
      else $error("channel lines moved at sample edge");

   a_r4_cs_covers: assert property (@(posedge clk) disable iff (!rst_n)
      (!sh_n_o || !rd_n_o) |-> !cs_n_o)
      else $error("strobe without chip select");

   a_r5_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) && sh_n_o) |-> !done_s)
      else $error("read before done");

   a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o)
      else $error("valid longer than one cycle");

   a_r2_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !ready_o) |=> $stable(sel_o))
      else $error("request taken while busy");

   a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready_o) && !err_o) |-> done_s)
      else $error("idle while done low");

   a_r10_err_release: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (ready_o && sh_n_o && rd_n_o && !valid_o))
      else $error("error without release");
endmodule

// File: tb/sim_hfadc_seq.sv
module sim_hfadc_seq;
   localparam int SAMP_C = 4;   // ceil(20/5)
   localparam int SET_C  = 2;   // ceil(10/5)
   localparam int RD_C   = 2;
   localparam int TMO_C  = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_i = 1'b0;
   logic [1:0] chan_i = 2'd0;
   logic mode_i = 1'b0;
   logic ready_o, cs_n_o, sh_n_o, rd_n_o, valid_o, err_o;
   logic [1:0] sel_o, chan_o;
   logic done_n_i = 1'b1;
   logic [9:0] data_i = 10'h155;
   logic [9:0] data_o;
   logic ready1, cs1, sh1, rd1, valid1, err1;
   logic [1:0] sel1, chan1;
   logic [9:0] data1;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   hfadc_seq #(.CLK_NS(5), .SAMPLE_NS(20), .SETTLE_NS(10), .RD_CYC(RD_C),
               .TMO_CYC(TMO_C), .DATA_W(10), .N_CH(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .mode_i(mode_i),
      .ready_o(ready_o), .cs_n_o(cs_n_o), .sh_n_o(sh_n_o), .rd_n_o(rd_n_o),
      .sel_o(sel_o), .done_n_i(done_n_i), .data_i(data_i), .data_o(data_o),
      .chan_o(chan_o), .valid_o(valid_o), .err_o(err_o));

   // two-input variant, only its channel lines are observed
   hfadc_seq #(.CLK_NS(5), .SAMPLE_NS(20), .SETTLE_NS(10), .RD_CYC(RD_C),
               .TMO_CYC(TMO_C), .DATA_W(10), .N_CH(2)) u1 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i), .mode_i(mode_i),
      .ready_o(ready1), .cs_n_o(cs1), .sh_n_o(sh1), .rd_n_o(rd1),
      .sel_o(sel1), .done_n_i(1'b1), .data_i(data_i), .data_o(data1),
      .chan_o(chan1), .valid_o(valid1), .err_o(err1));

   // converter model, updated on the falling edge
   int cyc = 0;
   int m_delay = 0, m_hold = 0, m_cnt = 0, m_hcnt = 0;
   int t_fall = -1, t_rise = -1;
   logic [9:0] m_new = 10'h155;
   logic m_psh = 1'b1, m_prd = 1'b1, m_garb = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (m_garb) begin
         data_i = m_new;
         m_garb = 1'b0;
      end
      if (m_delay > 0 && ((!m_psh && sh_n_o && rd_n_o && m_prd) ||
                          (m_psh && !sh_n_o && !rd_n_o))) begin
         m_cnt = m_delay;
      end else if (m_cnt > 0) begin
         m_cnt = m_cnt - 1;
         if (m_cnt == 0) begin
            done_n_i = 1'b0;
            data_i   = 10'h3FF;   // bus still settling
            m_garb   = 1'b1;
            t_fall   = cyc;
         end
      end
      if (!m_prd && rd_n_o) begin
         if (m_hold == 0) begin
            done_n_i = 1'b1;
            t_rise   = cyc;
         end else begin
            m_hcnt = m_hold;
         end
      end else if (m_hcnt > 0) begin
         m_hcnt = m_hcnt - 1;
         if (m_hcnt == 0) begin
            done_n_i = 1'b1;
            t_rise   = cyc;
         end
      end
      m_psh = sh_n_o;
      m_prd = rd_n_o;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // results of the last transaction
   int nshf, nshr, nrdf, nval, nerr, nrdy, shlo, vcnt, ecnt, csbad;
   logic [1:0] sel_at, sel1_at, ch_got;
   logic rd_at_shf;
   logic [9:0] dat_got;

   task automatic run_txn(input bit md, input logic [1:0] ch, input logic [9:0] val,
                          input int dly, input int hold, input int busy_ch);
      logic psh, prd;
      m_new = val; m_delay = dly; m_hold = hold;
      t_fall = -1; t_rise = -1;
      nshf = -1; nshr = -1; nrdf = -1; nval = -1; nerr = -1; nrdy = -1;
      shlo = 0; vcnt = 0; ecnt = 0; csbad = 0;
      sel_at = 2'bxx; sel1_at = 2'bxx; rd_at_shf = 1'b1; ch_got = 2'd0; dat_got = '0;
      @(negedge clk); #1;
      start_i = 1'b1; chan_i = ch; mode_i = md;
      @(negedge clk); #1;
      start_i = 1'b0;
      psh = 1'b1; prd = 1'b1;
      for (int k = 0; k < 400; k++) begin
         if (!sh_n_o) shlo++;
         if (!sh_n_o && psh) begin nshf = cyc; sel_at = sel_o; sel1_at = sel1; rd_at_shf = rd_n_o; end
         if (sh_n_o && !psh && nshr < 0) nshr = cyc;
         if (!rd_n_o && prd && nrdf < 0) nrdf = cyc;
         if (valid_o) begin vcnt++; nval = cyc; dat_got = data_o; ch_got = chan_o; end
         if (err_o) begin ecnt++; nerr = cyc; end
         if (cs_n_o && (!sh_n_o || !rd_n_o)) csbad++;
         psh = sh_n_o; prd = rd_n_o;
         if (ready_o) begin nrdy = cyc; break; end
         if (busy_ch >= 0 && k == 2) begin
            start_i = 1'b1; chan_i = 2'(busy_ch);
         end else begin
            start_i = 1'b0;
         end
         @(negedge clk); #1;
      end
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      chk(ready_o == 1'b1, "R1", "ready after reset", ready_o, 1);
      chk(cs_n_o && sh_n_o && rd_n_o, "R1", "strobes idle", {cs_n_o, sh_n_o, rd_n_o}, 7);
      chk(!valid_o && !err_o, "R1", "valid/err idle", {valid_o, err_o}, 0);
   endtask

   task automatic t_split();
      run_txn(1'b0, 2'd2, 10'h2A5, 6, 0, -1);
      chk(sel_at == 2'd2, "R3", "sel at sample fall", sel_at, 2);
      chk(sel1_at == 2'd0, "R3", "two-input sel", sel1_at, 0);
      chk(shlo == SAMP_C, "R5", "sample width", shlo, SAMP_C);
      chk(rd_at_shf == 1'b1, "R5", "rd high while sampling", rd_at_shf, 1);
      chk(nrdf == t_fall + 3, "R5", "read latency", nrdf - t_fall, 3);
      chk(nval == t_fall + 3 + RD_C, "R8", "capture cycle", nval - t_fall, 3 + RD_C);
      chk(dat_got == 10'h2A5, "R8", "data", dat_got, 10'h2A5);
      chk(ch_got == 2'd2, "R8", "tag", ch_got, 2);
      chk(vcnt == 1, "R8", "valid count", vcnt, 1);
      chk(csbad == 0, "R4", "strobe without cs", csbad, 0);
   endtask

   task automatic t_done_hold();
      run_txn(1'b0, 2'd1, 10'h0C3, 5, 6, -1);
      chk(nrdy == t_rise + 3, "R9", "ready after done high", nrdy - t_rise, 3);
      chk(dat_got == 10'h0C3 && ch_got == 2'd1, "R8", "data with hold", dat_got, 10'h0C3);
   endtask

   task automatic t_joined();
      run_txn(1'b1, 2'd3, 10'h0F3, 10, 0, -1);
      chk(rd_at_shf == 1'b0 && nrdf == nshf, "R6", "joined strobe fall", nrdf - nshf, 0);
      chk(shlo == 10 + 3 + SET_C, "R6", "joined strobe width", shlo, 10 + 3 + SET_C);
      chk(nval == t_fall + 3 + SET_C, "R7", "settle latency", nval - t_fall, 3 + SET_C);
      chk(dat_got == 10'h0F3, "R7", "fresh data", dat_got, 10'h0F3);
      chk(ch_got == 2'd3 && sel_at == 2'd3, "R3", "channel 3", ch_got, 3);
      chk(sel1_at == 2'd1, "R3", "two-input sel upper bit", sel1_at, 1);
      chk(csbad == 0, "R4", "joined cs", csbad, 0);
   endtask

   task automatic t_busy();
      run_txn(1'b1, 2'd0, 10'h1E1, 8, 0, 3);
      chk(ch_got == 2'd0, "R2", "tag after busy request", ch_got, 0);
      chk(sel_at == 2'd0, "R2", "sel after busy request", sel_at, 0);
      chk(vcnt == 1 && dat_got == 10'h1E1, "R2", "single result", vcnt, 1);
      repeat (4) @(negedge clk);
      #1;
      chk(ready_o && cs_n_o, "R2", "no second transaction", ready_o, 1);
   endtask

   task automatic t_timeout();
      run_txn(1'b0, 2'd1, 10'h111, 0, 0, -1);
      chk(ecnt == 1, "R10", "err pulses", ecnt, 1);
      chk(nerr == nshr + TMO_C, "R10", "timeout cycle", nerr - nshr, TMO_C);
      chk(nrdy == nerr, "R10", "ready with err", nrdy, nerr);
      chk(vcnt == 0, "R10", "no valid", vcnt, 0);
      chk(sh_n_o && rd_n_o && cs_n_o && !err_o, "R10", "strobes released",
          {sh_n_o, rd_n_o, cs_n_o, err_o}, 14);
   endtask

   task automatic t_after_timeout();
      run_txn(1'b0, 2'd0, 10'h3A0, 7, 0, -1);
      chk(dat_got == 10'h3A0 && vcnt == 1, "R5", "recovery transaction", dat_got, 10'h3A0);
      chk(nrdf == t_fall + 3, "R5", "read latency after error", nrdf - t_fall, 3);
   endtask

   initial begin
      #(5 * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      summary();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      t_reset();
      t_split();
      t_done_hold();
      t_joined();
      t_busy();
      t_timeout();
      t_after_timeout();
      summary();
   end
endmodule